// File: doc/BRIEF.md
# FSK Manchester Tag Waveform Generator

This block produces the one-bit load-modulation stream that a low-frequency proximity tag places on its coil. A value of 1 leaves the coil open and a value of 0 shorts it. A 44-bit identifier is loaded while the generator is idle. After a start command, the generator emits one sample for every rising edge of an external sample clock. It repeats the frame without a gap until a stop command arrives.

The frame is built only from two subcarrier cycle shapes. The slow shape has a period of 10 samples and the fast shape a period of 8. The frame begins with one lone fast cycle and a start marker made of deliberately invalid Manchester pairs. The 44 payload bits follow, and each bit is two half-bit groups of subcarrier cycles. A spare fast cycle precedes every fourth bit. The whole frame comes from nested counters, so no waveform memory is needed.

Top module: `fsk_tag_wavegen`

## Requirements
- R1: After reset, `mod_out` is 1 and `load_err` is 0.
- R2: A fast cycle is the 8 samples 1,1,0,0,0,0,0,0, and a fast group is 6 such cycles. A slow cycle is the 10 samples 1,1,1,0,0,0,0,0,0,0, and a slow group is 5 such cycles.
- R3: A payload bit of 1 is a slow group followed by a fast group. A payload bit of 0 is a fast group followed by a slow group. Bits go out from bit 43 down to bit 0. Bits 43..32 are `id_hi[11:0]` and bits 31..0 are `id_lo`.
- R4: The frame opens with one lone fast cycle. Eight marker groups follow, in the order fast, fast, fast, slow, slow, slow, fast, slow.
- R5: One lone fast cycle is placed before each payload bit whose index modulo 4 is 3. The frame is therefore 4800 samples long.
- R6: While running, `mod_out` takes its next sample at the clock edge that first sees `smp_clk` high. It holds that value until the next such edge.
- R7: The first sample of the frame follows the last sample of the frame directly, with no gap.
- R8: A load with `id_hi` above 0xFFF sets `load_err` to 1 and leaves no valid identifier. A start that follows has no effect, and `mod_out` stays 1. A valid load clears `load_err`.
- R9: A load while running is ignored, and the frame continues with the identifier loaded earlier.
- R10: A stop while running takes effect at the next sample edge. That sample and every later one is 1 until the next start.
- R11: A start while idle, with a valid identifier, restarts output at the first sample of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_hi | input | 16 | Upper identifier part; only values up to 0xFFF are accepted |
| id_lo | input | 32 | Lower 32 identifier bits |
| load | input | 1 | Capture the identifier (only while idle) |
| start | input | 1 | Begin emitting the frame (only while idle) |
| stop | input | 1 | Halt at the next sample edge |
| smp_clk | input | 1 | External sample clock, already synchronous to `clk` |
| mod_out | output | 1 | Modulation bit: 1 means coil open, 0 means coil shorted |
| load_err | output | 1 | Last load was rejected |

## Verification
The bench uses `smp_clk` as the sample strobe. It raises `smp_clk` after a falling clock edge. The next rising edge presents the new sample on `mod_out`, so the bench compares at the falling edge that follows. The expected sample comes from a queue-based frame model built from the requirements.

`load_err` settles one clock edge after `load`. A start takes effect on the first sample edge after it. A stop shows up as a 1 on the first sample edge after it. The bench samples each of these at the falling edge just after the rising edge where the result is due.

// File: rtl/fsk_tag_pkg.sv
package fsk_tag_pkg;
  typedef enum logic [1:0] {
    PH_LEAD = 2'd0,
    PH_MARK = 2'd1,
    PH_FILL = 2'd2,
    PH_DATA = 2'd3
  } fsk_phase_e;

  // bit i set: marker group i uses the slow (period 10) subcarrier
  localparam int unsigned MARK_GROUPS = 8;
  localparam logic [MARK_GROUPS-1:0] MARK_SLOW = 8'b1011_1000;
endpackage

// File: rtl/fsk_cycle_gen.sv
module fsk_cycle_gen #(
  parameter int unsigned FAST_PER = 8,
  parameter int unsigned FAST_HI  = 2,
  parameter int unsigned SLOW_PER = 10,
  parameter int unsigned SLOW_HI  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic step,
  input  logic slow,
  output logic level,
  output logic cyc_last
);
  localparam int unsigned MAXP = (SLOW_PER > FAST_PER) ? SLOW_PER : FAST_PER;
  localparam int unsigned SW   = $clog2(MAXP) + 1;

  logic [SW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] per_m1, hi_n;

  always_comb begin
    per_m1   = slow ? SW'(SLOW_PER - 1) : SW'(FAST_PER - 1);
    hi_n     = slow ? SW'(SLOW_HI) : SW'(FAST_HI);
    level    = (cnt_q < hi_n);
    cyc_last = (cnt_q == per_m1);
    cnt_d    = cnt_q;
    if (restart)   cnt_d = '0;
    else if (step) cnt_d = cyc_last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < SW'(MAXP));
endmodule

// File: rtl/fsk_frame_seq.sv
module fsk_frame_seq
  import fsk_tag_pkg::*;
#(
  parameter int unsigned ID_W       = 44,
  parameter int unsigned FAST_CYC   = 6,
  parameter int unsigned SLOW_CYC   = 5,
  parameter int unsigned FILL_EVERY = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            adv,
  input  logic [ID_W-1:0] id,
  output logic            slow
);
  localparam int unsigned MAXC = (FAST_CYC > SLOW_CYC) ? FAST_CYC : SLOW_CYC;
  localparam int unsigned CW   = $clog2(MAXC) + 1;
  localparam int unsigned BW   = $clog2(ID_W);
  localparam int unsigned GW   = $clog2(MARK_GROUPS);
  localparam bit FIRST_FILL    = ((ID_W - 1) % FILL_EVERY) == (FILL_EVERY - 1);

  fsk_phase_e     ph_q, ph_d;
  logic [CW-1:0]  cyc_q, cyc_d;
  logic [GW-1:0]  grp_q, grp_d;
  logic           half_q, half_d;
  logic [BW-1:0]  bit_q, bit_d;
  logic [CW-1:0]  grp_len_m1;
  logic           grp_end, cur_bit, nxt_fill;
  logic [BW-1:0]  nxt_bit;

  always_comb begin
    cur_bit = id[bit_q];
    case (ph_q)
      PH_MARK: slow = MARK_SLOW[grp_q];
      PH_DATA: slow = half_q ? ~cur_bit : cur_bit;
      default: slow = 1'b0;
    endcase
  end

  always_comb begin
    ph_d = ph_q; cyc_d = cyc_q; grp_d = grp_q; half_d = half_q; bit_d = bit_q;
    grp_len_m1 = slow ? CW'(SLOW_CYC - 1) : CW'(FAST_CYC - 1);
    grp_end    = (cyc_q == grp_len_m1);
    nxt_bit    = bit_q - 1'b1;
    nxt_fill   = (int'(nxt_bit) % FILL_EVERY) == (FILL_EVERY - 1);
    if (restart) begin
      ph_d = PH_LEAD; cyc_d = '0; grp_d = '0; half_d = 1'b0; bit_d = BW'(ID_W - 1);
    end else if (adv) begin
      case (ph_q)
        PH_LEAD: begin
          ph_d = PH_MARK; grp_d = '0; cyc_d = '0;
        end
        PH_MARK: begin
          if (!grp_end) cyc_d = cyc_q + 1'b1;
          else begin
            cyc_d = '0;
            if (grp_q == GW'(MARK_GROUPS - 1)) begin
              ph_d = FIRST_FILL ? PH_FILL : PH_DATA;
              half_d = 1'b0; bit_d = BW'(ID_W - 1);
            end else grp_d = grp_q + 1'b1;
          end
        end
        PH_FILL: begin
          ph_d = PH_DATA; cyc_d = '0; half_d = 1'b0;
        end
        default: begin
          if (!grp_end) cyc_d = cyc_q + 1'b1;
          else begin
            cyc_d = '0;
            if (!half_q) half_d = 1'b1;
            else begin
              half_d = 1'b0;
              if (bit_q == '0) begin
                ph_d = PH_LEAD; bit_d = BW'(ID_W - 1);
              end else begin
                bit_d = nxt_bit;
                ph_d  = nxt_fill ? PH_FILL : PH_DATA;
              end
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_LEAD; cyc_q <= '0; grp_q <= '0; half_q <= 1'b0; bit_q <= BW'(ID_W - 1);
    end else begin
      ph_q <= ph_d; cyc_q <= cyc_d; grp_q <= grp_d; half_q <= half_d; bit_q <= bit_d;
    end
  end

  p_bit_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q <= BW'(ID_W - 1));
  p_cyc_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_q < CW'(MAXC));
  p_lone_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !restart && (ph_q == PH_FILL || ph_q == PH_LEAD)) |=> ph_q != $past(ph_q));
endmodule

// File: rtl/fsk_tag_wavegen.sv
module fsk_tag_wavegen #(
  parameter int unsigned HI_IN_W    = 16,
  parameter int unsigned HI_W       = 12,
  parameter int unsigned LO_W       = 32,
  parameter int unsigned FAST_CYC   = 6,
  parameter int unsigned SLOW_CYC   = 5,
  parameter int unsigned FILL_EVERY = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HI_IN_W-1:0] id_hi,
  input  logic [LO_W-1:0]    id_lo,
  input  logic               load,
  input  logic               start,
  input  logic               stop,
  input  logic               smp_clk,
  output logic               mod_out,
  output logic               load_err
);
  localparam int unsigned ID_W = HI_W + LO_W;

  logic [1:0]      rst_s;
  logic            srst_n;
  logic            smp_q, smp_edge, tick;
  logic            run_q, run_d, stop_q, stop_d, ok_q, ok_d, err_d, out_d;
  logic [ID_W-1:0] id_q, id_d;
  logic            hi_bad, start_acc, slow, level, cyc_last, seq_adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_s <= 2'b00;
    else        rst_s <= {rst_s[0], 1'b1};
  end
  assign srst_n = rst_s[1];

  always_comb begin
    smp_edge  = smp_clk & ~smp_q;
    tick      = run_q & smp_edge;
    hi_bad    = (id_hi > HI_IN_W'((1 << HI_W) - 1));
    start_acc = start & ~run_q & ok_q;
    seq_adv   = tick & ~stop_q & cyc_last;
    run_d = run_q; stop_d = stop_q; ok_d = ok_q; err_d = load_err; id_d = id_q; out_d = mod_out;
    if (load && !run_q) begin
      if (hi_bad) begin
        err_d = 1'b1; ok_d = 1'b0;
      end else begin
        err_d = 1'b0; ok_d = 1'b1; id_d = {id_hi[HI_W-1:0], id_lo};
      end
    end
    if (start_acc) run_d = 1'b1;
    if (stop && run_q) stop_d = 1'b1;
    if (tick) begin
      if (stop_q || stop) begin
        out_d = 1'b1; run_d = 1'b0; stop_d = 1'b0;
      end else out_d = level;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      smp_q <= 1'b0; run_q <= 1'b0; stop_q <= 1'b0; ok_q <= 1'b0;
      load_err <= 1'b0; mod_out <= 1'b1; id_q <= '0;
    end else begin
      smp_q <= smp_clk; run_q <= run_d; stop_q <= stop_d; ok_q <= ok_d;
      load_err <= err_d; mod_out <= out_d; id_q <= id_d;
    end
  end

  fsk_cycle_gen #(
    .FAST_PER(8), .FAST_HI(2), .SLOW_PER(10), .SLOW_HI(3)
  ) u_cyc (
    .clk(clk), .rst_n(srst_n), .restart(start_acc), .step(tick & ~stop_q & ~stop),
    .slow(slow), .level(level), .cyc_last(cyc_last)
  );

  fsk_frame_seq #(
    .ID_W(ID_W), .FAST_CYC(FAST_CYC), .SLOW_CYC(SLOW_CYC), .FILL_EVERY(FILL_EVERY)
  ) u_seq (
    .clk(clk), .rst_n(srst_n), .restart(start_acc), .adv(seq_adv), .id(id_q), .slow(slow)
  );

  p_idle_open_r10: assert property (@(posedge clk) disable iff (!srst_n)
    !run_q |-> mod_out);
  p_hold_r6: assert property (@(posedge clk) disable iff (!srst_n)
    !smp_clk |=> $stable(mod_out));
  p_err_blocks_r8: assert property (@(posedge clk) disable iff (!srst_n)
    load_err |-> !run_q);
  p_load_ignored_r9: assert property (@(posedge clk) disable iff (!srst_n)
    run_q |=> $stable(id_q));
endmodule

// File: tb/fsk_tag_wavegen_tb.sv
module fsk_tag_wavegen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] id_hi = '0;
  logic [31:0] id_lo = '0;
  logic        load = 1'b0, start = 1'b0, stop = 1'b0, smp_clk = 1'b0;
  logic        mod_out, load_err;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;
  bit frame[$];
  int ptr = 0;
  bit m_run = 0, m_stop = 0;

  always #10 clk = ~clk;

  fsk_tag_wavegen u_dut (
    .clk(clk), .rst_n(rst_n), .id_hi(id_hi), .id_lo(id_lo), .load(load),
    .start(start), .stop(stop), .smp_clk(smp_clk), .mod_out(mod_out), .load_err(load_err)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b ptr=%0d", req, act, exp, ptr);
    end
  endtask

  task automatic push_cyc(int per, int hi);
    for (int k = 0; k < per; k++) frame.push_back(k < hi);
  endtask

  task automatic push_grp(bit slw);
    if (slw) for (int k = 0; k < 5; k++) push_cyc(10, 3);
    else     for (int k = 0; k < 6; k++) push_cyc(8, 2);
  endtask

  task automatic build(logic [43:0] id);
    frame.delete();
    push_cyc(8, 2);
    push_grp(0); push_grp(0); push_grp(0); push_grp(1);
    push_grp(1); push_grp(1); push_grp(0); push_grp(1);
    for (int b = 43; b >= 0; b--) begin
      if (b % 4 == 3) push_cyc(8, 2);
      if (id[b]) begin push_grp(1); push_grp(0); end
      else       begin push_grp(0); push_grp(1); end
    end
  endtask

  task automatic tick(string req);
    bit exp;
    @(negedge clk); smp_clk = 1'b1;
    @(negedge clk); smp_clk = 1'b0;
    if (m_run) begin
      if (m_stop) begin exp = 1; m_run = 0; m_stop = 0; end
      else begin exp = frame[ptr]; ptr = (ptr + 1) % frame.size(); end
    end else exp = 1;
    chk(req, mod_out, exp);
    @(negedge clk);
    chk("R6", mod_out, exp);
  endtask

  task automatic ticks(int n, string req);
    for (int i = 0; i < n; i++) tick(req);
  endtask

  task automatic do_load(logic [15:0] h, logic [31:0] l);
    @(negedge clk); id_hi = h; id_lo = l; load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic do_start(bit accepted);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (accepted) begin m_run = 1; ptr = 0; end
  endtask

  initial begin
    while (!done) begin
      @(posedge clk); cycles++;
      if (cycles > 200000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected<=200000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", mod_out, 1'b1);
    chk("R1", load_err, 1'b0);

    // R8: oversize upper part rejected, start has no effect
    do_load(16'h1000, 32'h0);
    chk("R8", load_err, 1'b1);
    do_start(0);
    ticks(20, "R8");

    // R2 R3 R4 R5 R7: identifier A, full frame plus wrap
    do_load(16'h0ABC, 32'h1234_5678);
    chk("R8", load_err, 1'b0);
    build(44'hABC_1234_5678);
    do_start(1);
    ticks(frame.size(), "R3");
    ticks(120, "R7");

    // R9: load while running ignored
    do_load(16'h0FFF, 32'hFFFF_FFFF);
    ticks(frame.size(), "R9");

    // R10: stop mid-frame
    @(negedge clk); stop = 1'b1; m_stop = 1;
    @(negedge clk); stop = 1'b0;
    ticks(30, "R10");

    // R11: restart with all-ones identifier
    do_load(16'h0FFF, 32'hFFFF_FFFF);
    build(44'hFFF_FFFF_FFFF);
    do_start(1);
    ticks(frame.size() + 10, "R11");

    // R4 R5: all-zero identifier
    @(negedge clk); stop = 1'b1; m_stop = 1;
    @(negedge clk); stop = 1'b0;
    tick("R10");
    do_load(16'h0000, 32'h0000_0000);
    build(44'h0);
    do_start(1);
    ticks(frame.size(), "R5");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule